// File: doc/BRIEF.md
# Sampling Phase Hill-Climb Controller

This block tunes the phase offset of the auxiliary clock that samples the equalizer error. The equalizer's adapted threshold code is highest when that clock sits at the best point. The block runs a perturb-and-observe search. At each accepted step strobe it compares the incoming threshold code with the code it stored at the previous step. A smaller value reverses the search direction. An equal or larger value keeps it.

At every decision step the block adds a programmable gain to a saturating accumulator, or subtracts it, according to the chosen direction. This happens even when the two codes are equal, so the search cannot stall. The upper bits of the accumulator form the phase offset code that goes to the clock recovery loop.

The search is held idle until the clock recovery and coefficient adaptation loops report convergence. That report drives the enable input. After a programmed number of decision steps the block raises a done flag and holds the offset frozen until it is enabled again.

Top module: `smp_phase_climb`

## Requirements
- R1: While `rst_n` is low, `ofs_code` equals the parameter `NOMINAL` (default 64), `dir_down` is 0 and `search_done` is 0.
- R2: While `en_search` is low, the block is re-armed. The accumulator holds `NOMINAL` in its top `OUT_W` bits and zeros below them. `dir_down` is 0 (increasing), `search_done` is 0, and step strobes have no effect on any output.
- R3: The first accepted strobe after enabling only stores `thr_code` as the previous threshold. `ofs_code` and `dir_down` do not change.
- R4: On a later accepted strobe with `thr_code` greater than or equal to the stored threshold, `dir_down` keeps its value.
- R5: On a later accepted strobe with `thr_code` smaller than the stored threshold, `dir_down` is inverted. 1 means decreasing and 0 means increasing.
- R6: Every decision step adds `gain` to the 24-bit accumulator when the new direction is increasing, and subtracts it when the new direction is decreasing. This holds when the codes are equal. `ofs_code` is accumulator bits [23:17]. The result is registered on the clock edge that samples the strobe.
- R7: The accumulator saturates at 0 and at 2^24-1 instead of wrapping.
- R8: After `run_len` decision steps, `search_done` rises on the next clock edge, and later strobes are ignored. With `run_len` = 0 it rises on the first enabled edge and no step is ever taken.
- R9: While `search_done` is high and `en_search` stays high, `ofs_code`, `dir_down` and `search_done` stay constant. Dropping the enable and raising it again restarts the search from the re-armed state.
- R10: Clock edges without an accepted strobe leave the offset, direction and stored threshold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_search | input | 1 | High once the other adaptation loops have converged |
| step_stb | input | 1 | One-cycle strobe marking a new threshold sample |
| thr_code | input | THR_W (7) | Adapted threshold code |
| gain | input | GAIN_W (16) | Accumulator step size (search bandwidth) |
| run_len | input | RUN_W (16) | Number of decision steps before freezing |
| ofs_code | output | OUT_W (7) | Phase offset code for the clock recovery loop |
| dir_down | output | 1 | Current search direction, 1 = decreasing |
| search_done | output | 1 | Search finished, offset frozen |

## Verification
The capture, the direction decision and the accumulator update all land on the same clock edge that samples the strobe. `ofs_code` and `dir_down` are therefore due one edge after the strobe. `search_done` comes one edge after the step that reached the run length. The bench drives every input at the falling edge. It advances its own model at the rising edge with those same input values and compares all three outputs at the following falling edge, so every expected value lines up with the edge that produced it. Saturation, the zero-length run and re-arming are driven as directed sequences. Random threshold walks and strobe densities fill in the rest.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;

  // Search direction carried on dir_down
  typedef enum logic {
    SEARCH_UP   = 1'b0,
    SEARCH_DOWN = 1'b1
  } search_dir_e;

  localparam int unsigned DEF_THR_W  = 7;
  localparam int unsigned DEF_ACC_W  = 24;
  localparam int unsigned DEF_OUT_W  = 7;
  localparam int unsigned DEF_GAIN_W = 16;
  localparam int unsigned DEF_RUN_W  = 16;

endpackage

// File: rtl/spc_thr_track.sv
`timescale 1ns/1ps
// Stores the previous threshold and decides the search direction.
module spc_thr_track
  import spc_pkg::*;
#(
  parameter int unsigned THR_W = DEF_THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,       // re-arm while search disabled
  input  logic             take,      // accepted strobe
  input  logic [THR_W-1:0] thr_in,
  output logic             first_q,   // next accepted strobe only captures
  output search_dir_e      dir_q,
  output search_dir_e      dir_next,  // direction used by this step
  output logic [THR_W-1:0] prev_q
);

  logic             first_d;
  search_dir_e      dir_d;
  logic [THR_W-1:0] prev_d;
  logic             dropped;

  assign dropped  = (thr_in < prev_q);
  assign dir_next = dropped ? search_dir_e'(~dir_q) : dir_q;

  always_comb begin
    first_d = first_q;
    dir_d   = dir_q;
    prev_d  = prev_q;
    if (arm) begin
      first_d = 1'b1;
      dir_d   = SEARCH_UP;
      prev_d  = '0;
    end else if (take) begin
      prev_d  = thr_in;
      first_d = 1'b0;
      if (!first_q) begin
        dir_d = dir_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      dir_q   <= SEARCH_UP;
      prev_q  <= '0;
    end else begin
      first_q <= first_d;
      dir_q   <= dir_d;
      prev_q  <= prev_d;
    end
  end

endmodule

// File: rtl/spc_sat_accum.sv
`timescale 1ns/1ps
// Saturating phase accumulator; the offset code is its top bits.
module spc_sat_accum
  import spc_pkg::*;
#(
  parameter int unsigned ACC_W   = DEF_ACC_W,
  parameter int unsigned GAIN_W  = DEF_GAIN_W,
  parameter int unsigned OUT_W   = DEF_OUT_W,
  parameter int unsigned NOMINAL = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              move,
  input  search_dir_e       dir_sel,
  input  logic [GAIN_W-1:0] gain,
  output logic [ACC_W-1:0]  acc_q,
  output logic [OUT_W-1:0]  ofs
);

  localparam int unsigned      LOW_W    = ACC_W - OUT_W;
  localparam logic [OUT_W-1:0] NOM_CODE = OUT_W'(NOMINAL);
  localparam logic [ACC_W-1:0] PRELOAD  = {NOM_CODE, {LOW_W{1'b0}}};
  localparam logic [ACC_W-1:0] ACC_MAX  = {ACC_W{1'b1}};

  logic [ACC_W-1:0] gain_ext;
  logic [ACC_W:0]   sum_wide;
  logic [ACC_W-1:0] up_val;
  logic [ACC_W-1:0] dn_val;
  logic [ACC_W-1:0] acc_d;

  generate
    if (GAIN_W < ACC_W) begin : g_pad
      assign gain_ext = {{(ACC_W-GAIN_W){1'b0}}, gain};
    end else begin : g_trim
      assign gain_ext = gain[ACC_W-1:0];
    end
  endgenerate

  assign sum_wide = {1'b0, acc_q} + {1'b0, gain_ext};
  assign up_val   = sum_wide[ACC_W] ? ACC_MAX : sum_wide[ACC_W-1:0];
  assign dn_val   = (gain_ext > acc_q) ? '0 : (acc_q - gain_ext);

  always_comb begin
    acc_d = acc_q;
    if (arm) begin
      acc_d = PRELOAD;
    end else if (move) begin
      acc_d = (dir_sel == SEARCH_DOWN) ? dn_val : up_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= PRELOAD;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign ofs = acc_q[ACC_W-1 -: OUT_W];

endmodule

// File: rtl/spc_run_timer.sv
`timescale 1ns/1ps
// Counts decision steps and raises done at the programmed run length.
module spc_run_timer
  import spc_pkg::*;
#(
  parameter int unsigned RUN_W = DEF_RUN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             move,
  input  logic [RUN_W-1:0] run_len,
  output logic             at_limit,
  output logic             done_q
);

  logic [RUN_W-1:0] cnt_q;
  logic [RUN_W-1:0] cnt_d;
  logic             done_d;

  assign at_limit = (cnt_q == run_len);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (arm) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (at_limit) begin
        done_d = 1'b1;
      end else if (move) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/smp_phase_climb.sv
`timescale 1ns/1ps
module smp_phase_climb
  import spc_pkg::*;
#(
  parameter int unsigned THR_W   = DEF_THR_W,
  parameter int unsigned ACC_W   = DEF_ACC_W,
  parameter int unsigned OUT_W   = DEF_OUT_W,
  parameter int unsigned GAIN_W  = DEF_GAIN_W,
  parameter int unsigned RUN_W   = DEF_RUN_W,
  parameter int unsigned NOMINAL = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_search,
  input  logic              step_stb,
  input  logic [THR_W-1:0]  thr_code,
  input  logic [GAIN_W-1:0] gain,
  input  logic [RUN_W-1:0]  run_len,
  output logic [OUT_W-1:0]  ofs_code,
  output logic              dir_down,
  output logic              search_done
);

  logic             arm;
  logic             accept;
  logic             move_step;
  logic             first_q;
  logic             at_limit;
  logic             done_q;
  search_dir_e      dir_q;
  search_dir_e      dir_next;
  logic [THR_W-1:0] prev_thr;
  logic [ACC_W-1:0] acc_val;

  assign arm       = ~en_search;
  assign accept    = en_search & step_stb & ~done_q & ~at_limit;
  assign move_step = accept & ~first_q;

  spc_thr_track #(.THR_W(THR_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .take     (accept),
    .thr_in   (thr_code),
    .first_q  (first_q),
    .dir_q    (dir_q),
    .dir_next (dir_next),
    .prev_q   (prev_thr)
  );

  spc_sat_accum #(
    .ACC_W(ACC_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .NOMINAL(NOMINAL)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .move    (move_step),
    .dir_sel (dir_next),
    .gain    (gain),
    .acc_q   (acc_val),
    .ofs     (ofs_code)
  );

  spc_run_timer #(.RUN_W(RUN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .move     (move_step),
    .run_len  (run_len),
    .at_limit (at_limit),
    .done_q   (done_q)
  );

  assign dir_down    = (dir_q == SEARCH_DOWN);
  assign search_done = done_q;

endmodule

// File: rtl/spc_checker.sv
`timescale 1ns/1ps
module spc_checker #(
  parameter int unsigned THR_W   = 7,
  parameter int unsigned ACC_W   = 24,
  parameter int unsigned OUT_W   = 7,
  parameter int unsigned GAIN_W  = 16,
  parameter int unsigned NOMINAL = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_search,
  input logic [THR_W-1:0]  thr_code,
  input logic [GAIN_W-1:0] gain,
  input logic [OUT_W-1:0]  ofs_code,
  input logic              dir_down,
  input logic              search_done,
  input logic [THR_W-1:0]  prev_thr,
  input logic              move_step,
  input logic [ACC_W-1:0]  acc_val
);

  // R2
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_search |=> (ofs_code == OUT_W'(NOMINAL)) && !dir_down && !search_done);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search_done && en_search) |=> $stable(ofs_code) && $stable(dir_down) && search_done);

  // R4
  keep_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move_step && (thr_code >= prev_thr)) |=> (dir_down == $past(dir_down)));

  // R5
  flip_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move_step && (thr_code < prev_thr)) |=> (dir_down != $past(dir_down)));

  // R6
  always_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move_step && (gain != '0)) |=>
      (acc_val != $past(acc_val)) || (acc_val == '0) || (acc_val == {ACC_W{1'b1}}));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_search && !move_step) |=> $stable(acc_val) && $stable(dir_down));

endmodule

bind smp_phase_climb spc_checker #(
  .THR_W(THR_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W), .NOMINAL(NOMINAL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_search   (en_search),
  .thr_code    (thr_code),
  .gain        (gain),
  .ofs_code    (ofs_code),
  .dir_down    (dir_down),
  .search_done (search_done),
  .prev_thr    (prev_thr),
  .move_step   (move_step),
  .acc_val     (acc_val)
);

// File: tb/smp_phase_climb_tb.sv
`timescale 1ns/1ps
module smp_phase_climb_tb;

  localparam longint ACC_MAX = 64'd16777215;
  localparam longint PRELOAD = 64'd64 << 17;

  logic        clk;
  logic        rst_n;
  logic        en_search;
  logic        step_stb;
  logic [6:0]  thr_code;
  logic [15:0] gain;
  logic [15:0] run_len;
  logic [6:0]  ofs_code;
  logic        dir_down;
  logic        search_done;

  int n_vec;
  int n_bad;
  bit finished;

  // bench model state
  longint m_acc;
  bit     m_dir;
  bit     m_first;
  int     m_prev;
  int     m_cnt;
  bit     m_done;

  smp_phase_climb u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_search   (en_search),
    .step_stb    (step_stb),
    .thr_code    (thr_code),
    .gain        (gain),
    .run_len     (run_len),
    .ofs_code    (ofs_code),
    .dir_down    (dir_down),
    .search_done (search_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint sat_move(longint acc, bit down, longint g);
    if (!down) return (acc + g > ACC_MAX) ? ACC_MAX : acc + g;
    return (g > acc) ? 64'd0 : acc - g;
  endfunction

  task automatic mdl_arm();
    m_acc = PRELOAD; m_dir = 1'b0; m_first = 1'b1;
    m_prev = 0; m_cnt = 0; m_done = 1'b0;
  endtask

  task automatic mdl_edge();
    if (!en_search) begin
      mdl_arm();                                  // R2
    end else if (!m_done) begin
      if (m_cnt == int'(run_len)) m_done = 1'b1;  // R8
      else if (step_stb) begin
        if (m_first) begin                        // R3
          m_prev = int'(thr_code); m_first = 1'b0;
        end else begin
          if (int'(thr_code) < m_prev) m_dir = ~m_dir;  // R5, else R4
          m_prev = int'(thr_code);
          m_acc = sat_move(m_acc, m_dir, longint'(gain)); // R6, R7
          m_cnt++;
        end
      end
    end
  endtask

  task automatic check(string req);
    logic [6:0] e_ofs;
    e_ofs = 7'(m_acc >> 17);
    n_vec++;
    if (ofs_code !== e_ofs || dir_down !== m_dir || search_done !== m_done) begin
      n_bad++;
      $display("FAIL %s: ofs=%0d dir=%0b done=%0b expected ofs=%0d dir=%0b done=%0b",
               req, ofs_code, dir_down, search_done, e_ofs, m_dir, m_done);
    end
  endtask

  // inputs are driven at the falling edge; model advances at the rising edge
  task automatic tick(bit e, bit s, int t, string req);
    en_search = e; step_stb = s; thr_code = 7'(t);
    @(posedge clk);
    mdl_edge();
    @(negedge clk);
    check(req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int seed;
    int t;
    seed = 32'h5EA5_0001;
    void'($urandom(seed));
    n_vec = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; en_search = 1'b0; step_stb = 1'b0; thr_code = '0;
    gain = 16'd4096; run_len = 16'd1000;
    mdl_arm();
    repeat (3) @(negedge clk);
    check("R1");                          // R1 reset state
    rst_n = 1'b1;

    // R2: disabled, strobes ignored
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 10 * i, "R2");

    // R3: first strobe only captures
    tick(1'b1, 1'b1, 50, "R3");
    // R6: equal codes still move
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 50, "R6");
    // R4: rising keeps direction
    tick(1'b1, 1'b1, 60, "R4");
    // R5: falling flips direction
    tick(1'b1, 1'b1, 40, "R5");
    tick(1'b1, 1'b1, 30, "R5");
    // R10: idle edges hold state
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, i * 33, "R10");

    // R7: saturate high then low
    tick(1'b0, 1'b0, 0, "R2");
    gain = 16'hFFFF;
    tick(1'b1, 1'b1, 20, "R3");
    for (int i = 0; i < 140; i++) tick(1'b1, 1'b1, 20, "R7");
    tick(1'b1, 1'b1, 5, "R5");
    for (int i = 0; i < 270; i++) tick(1'b1, 1'b1, 5, "R7");

    // R8 / R9: short run then frozen
    tick(1'b0, 1'b0, 0, "R2");
    gain = 16'd20000; run_len = 16'd5;
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b1, 70 - i, "R8");
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, i * 9, "R9");
    tick(1'b0, 1'b1, 3, "R9");
    tick(1'b1, 1'b1, 3, "R9");
    tick(1'b1, 1'b1, 9, "R9");
    // R8: zero-length run
    tick(1'b0, 1'b0, 0, "R2");
    run_len = 16'd0;
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 100 - i, "R8");

    // random walks with several strobe densities and run lengths
    t = 64;
    for (int blk = 0; blk < 12; blk++) begin
      tick(1'b0, 1'b0, 0, "R2");
      gain    = 16'($urandom_range(1, (blk % 3 == 0) ? 65535 : 3000));
      run_len = 16'($urandom_range(0, (blk % 4 == 0) ? 20 : 400));
      for (int i = 0; i < 300; i++) begin
        t = t + $urandom_range(0, 6) - 3;
        if (t < 0) t = 0;
        if (t > 127) t = 127;
        tick(($urandom_range(0, 99) != 0), ($urandom_range(0, 3) <= blk % 4),
             t, "R6");
      end
    end

    finish_run();
  end

endmodule